// File: doc/BRIEF.md
# Deferring Write Response Agent

This block is the target-side response engine of a split-transaction processor bus. It accepts one single-beat write at a time and ends it with a deferred response. The write data is still taken within the same transaction, so the requester keeps nothing but the deferred tag for a later reply. A request arrives in two consecutive clocks. The first clock carries the address and the transaction type. The second carries the deferred tag (agent type, agent number and transaction number), the byte enables and an active-low defer-enable pin.

In the snoop clock the block decides whether it may defer. If it may, it raises the defer indication. It then waits for the data bus to be free, pulses target-ready for one clock and drives the deferred response one clock later. It captures the data beat once data-ready validates it. If deferral is not allowed, or there is no room to park the write, it answers with a retry and takes no data. A captured write goes into a one-entry forwarding slot. That slot presents address, lane-masked data, byte enables and the deferred tag to downstream logic over a valid/ready handshake.

Top module: `deferred_write_agent`

## Requirements
- R1: While rst_ni is low, and in the first clock after it goes high, defer_o, trdy_o, rsp_valid_o and fwd_valid_o are 0 and rsp_code_o is 3'b000.
- R2: A transaction starts only when req_valid_i is high in an idle clock with req_type_i equal to 2'b01 (memory write) or 2'b11 (I/O write). The types 2'b00 and 2'b10 are ignored, and so is any request presented while a transaction is in progress. An ignored request produces no defer, target-ready or response.
- R3: The address is sampled in the request clock. The deferred tag, byte enables and req_defer_en_ni are sampled in the clock after it. Values on those pins in any other clock have no effect.
- R4: In the third clock of a transaction (the snoop clock), defer_o is high for exactly that clock if and only if req_defer_en_ni was 1 (deasserted) in the second clock and the forwarding slot is empty or is handed off (fwd_valid_o and fwd_ready_i both high) in that same clock.
- R5: When defer_o stays low in the snoop clock, the next clock carries rsp_valid_o=1 with rsp_code_o=3'b001 (retry). There is no target-ready, no data is taken, and the forwarding slot is unchanged.
- R6: After a deferred snoop clock, trdy_o is high for exactly one clock. That clock is the first clock, starting with the one right after the snoop clock, whose preceding clock had data_busy_i low.
- R7: rsp_valid_o is high for exactly the clock after trdy_o, with rsp_code_o=3'b010 (deferred). rsp_code_o is 3'b000 whenever rsp_valid_o is low. The codes 3'b011 (no data) and 3'b100 (hard failure) are reserved for the later reply.
- R8: The data beat is the wr_data_i value of the first clock, at least two clocks after trdy_o, in which data_ready_i is high. data_ready_i in the response clock is ignored.
- R9: In the clock after capture, fwd_valid_o is 1 with the captured address, byte enables and tag. fwd_data_o carries the data with every lane whose byte enable is 0 forced to zero. All of these stay stable until a clock with fwd_ready_i high, after which fwd_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | First request clock marker |
| req_type_i | input | 2 | Transaction type (first clock) |
| req_addr_i | input | ADDR_W | Write address (first clock) |
| req_did_i | input | DID_W | Deferred tag (second clock) |
| req_be_i | input | DATA_W/8 | Byte enables (second clock) |
| req_defer_en_ni | input | 1 | Defer-enable, active low; 1 permits deferral (second clock) |
| data_busy_i | input | 1 | Data bus busy |
| data_ready_i | input | 1 | Data beat valid |
| wr_data_i | input | DATA_W | Write data beat |
| defer_o | output | 1 | Defer indication in the snoop clock |
| trdy_o | output | 1 | Target ready, one clock |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 3 | Response code |
| fwd_valid_o | output | 1 | Forwarding slot holds a write |
| fwd_ready_i | input | 1 | Downstream takes the write |
| fwd_addr_o | output | ADDR_W | Forwarded address |
| fwd_data_o | output | DATA_W | Forwarded data, disabled lanes zero |
| fwd_be_o | output | DATA_W/8 | Forwarded byte enables |
| fwd_did_o | output | DID_W | Forwarded deferred tag |

## Verification
Two functions can meet in the same clock: the snoop-clock decision on whether the forwarding slot has room, and downstream draining that slot. The bench leaves the previous write parked in the slot. It then raises fwd_ready_i exactly in the snoop clock of the next write and expects defer_o high with the new write forwarded later. With fwd_ready_i held low in that clock, it expects a retry and the parked write intact. A second overlap, new requests arriving while the data phase is pending, is provoked by holding req_valid_i high through the wait clocks. It is judged by silence on defer_o and rsp_valid_o afterwards.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PKTB,
    ST_SNOOP,
    ST_TWAIT,
    ST_TRDY,
    ST_RESP,
    ST_DATA,
    ST_RETRY
  } phase_e;

  localparam logic [2:0] RSP_NONE     = 3'b000;
  localparam logic [2:0] RSP_RETRY    = 3'b001;
  localparam logic [2:0] RSP_DEFER    = 3'b010;
  localparam logic [2:0] RSP_NODATA   = 3'b011;
  localparam logic [2:0] RSP_HARDFAIL = 3'b100;

  localparam logic [1:0] TYP_MEM_WR = 2'b01;
  localparam logic [1:0] TYP_IO_WR  = 2'b11;

  function automatic logic is_write(input logic [1:0] typ);
    return (typ == TYP_MEM_WR) || (typ == TYP_IO_WR);
  endfunction

endpackage

// File: rtl/dwr_req_latch.sv
module dwr_req_latch #(
  parameter int ADDR_W = 32,
  parameter int DID_W  = 8,
  parameter int BE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DID_W-1:0]  did_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              defer_en_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DID_W-1:0]  did_o,
  output logic [BE_W-1:0]   be_o,
  output logic              defer_ok_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DID_W-1:0]  did_q;
  logic [BE_W-1:0]   be_q;
  logic              den_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (cap_a_i) begin
      addr_q <= addr_i;
    end
  end

  // second packet; reset value forbids deferral
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      did_q   <= '0;
      be_q    <= '0;
      den_n_q <= 1'b0;
    end else if (cap_b_i) begin
      did_q   <= did_i;
      be_q    <= be_i;
      den_n_q <= defer_en_ni;
    end
  end

  assign addr_o     = addr_q;
  assign did_o      = did_q;
  assign be_o       = be_q;
  assign defer_ok_o = den_n_q;

endmodule

// File: rtl/dwr_phase_fsm.sv
module dwr_phase_fsm
  import dwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_type_i,
  input  logic       defer_ok_i,
  input  logic       slot_free_i,
  input  logic       data_busy_i,
  input  logic       data_ready_i,
  output logic       cap_a_o,
  output logic       cap_b_o,
  output logic       load_o,
  output logic       defer_o,
  output logic       trdy_o,
  output logic       rsp_valid_o,
  output logic [2:0] rsp_code_o
);

  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i && is_write(req_type_i)) state_d = ST_PKTB;
      ST_PKTB:  state_d = ST_SNOOP;
      ST_SNOOP: begin
        if (!defer_o)          state_d = ST_RETRY;
        else if (!data_busy_i) state_d = ST_TRDY;
        else                   state_d = ST_TWAIT;
      end
      ST_TWAIT: if (!data_busy_i) state_d = ST_TRDY;
      ST_TRDY:  state_d = ST_RESP;
      ST_RESP:  state_d = ST_DATA;
      ST_DATA:  if (data_ready_i) state_d = ST_IDLE;
      ST_RETRY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign cap_a_o     = (state_q == ST_IDLE) && req_valid_i && is_write(req_type_i);
  assign cap_b_o     = (state_q == ST_PKTB);
  assign defer_o     = (state_q == ST_SNOOP) && defer_ok_i && slot_free_i;
  assign trdy_o      = (state_q == ST_TRDY);
  assign load_o      = (state_q == ST_DATA) && data_ready_i;
  assign rsp_valid_o = (state_q == ST_RESP) || (state_q == ST_RETRY);

  always_comb begin
    rsp_code_o = RSP_NONE;
    if (state_q == ST_RESP)  rsp_code_o = RSP_DEFER;
    if (state_q == ST_RETRY) rsp_code_o = RSP_RETRY;
  end

  AST_DEFER_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_o |=> !defer_o); // R4
  AST_TRDY_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |=> !trdy_o); // R6
  AST_TRDY_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trdy_o) |-> !$past(data_busy_i)); // R6
  AST_RSP_AFTER_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |=> (rsp_valid_o && rsp_code_o == RSP_DEFER)); // R7
  AST_RETRY_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == RSP_RETRY) |=> !load_o); // R5

endmodule

// File: rtl/dwr_fwd_slot.sv
module dwr_fwd_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DID_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DID_W-1:0]    did_i,
  output logic                slot_free_o,
  output logic                fwd_valid_o,
  input  logic                fwd_ready_i,
  output logic [ADDR_W-1:0]   fwd_addr_o,
  output logic [DATA_W-1:0]   fwd_data_o,
  output logic [DATA_W/8-1:0] fwd_be_o,
  output logic [DID_W-1:0]    fwd_did_o
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] masked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = be_i[g] ? data_i[g*8 +: 8] : 8'h00;
  end

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  be_q;
  logic [DID_W-1:0]  did_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      did_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      data_q  <= masked;
      be_q    <= be_i;
      did_q   <= did_i;
    end else if (valid_q && fwd_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // a hand-off in the same clock frees the entry for a new reservation
  assign slot_free_o = !valid_q || fwd_ready_i;
  assign fwd_valid_o = valid_q;
  assign fwd_addr_o  = addr_q;
  assign fwd_data_o  = data_q;
  assign fwd_be_o    = be_q;
  assign fwd_did_o   = did_q;

  AST_LOAD_INTO_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!fwd_valid_o || fwd_ready_i)); // R4
  AST_FWD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !fwd_ready_i) |=> (fwd_valid_o && $stable(fwd_data_o)
                                       && $stable(fwd_did_o))); // R9

endmodule

// File: rtl/deferred_write_agent.sv
module deferred_write_agent #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DID_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_type_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DID_W-1:0]    req_did_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic                req_defer_en_ni,
  input  logic                data_busy_i,
  input  logic                data_ready_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                defer_o,
  output logic                trdy_o,
  output logic                rsp_valid_o,
  output logic [2:0]          rsp_code_o,
  output logic                fwd_valid_o,
  input  logic                fwd_ready_i,
  output logic [ADDR_W-1:0]   fwd_addr_o,
  output logic [DATA_W-1:0]   fwd_data_o,
  output logic [DATA_W/8-1:0] fwd_be_o,
  output logic [DID_W-1:0]    fwd_did_o
);

  localparam int BE_W = DATA_W / 8;

  logic              cap_a, cap_b, load, defer_ok, slot_free;
  logic [ADDR_W-1:0] lat_addr;
  logic [DID_W-1:0]  lat_did;
  logic [BE_W-1:0]   lat_be;

  dwr_req_latch #(.ADDR_W(ADDR_W), .DID_W(DID_W), .BE_W(BE_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_a_i     (cap_a),
    .cap_b_i     (cap_b),
    .addr_i      (req_addr_i),
    .did_i       (req_did_i),
    .be_i        (req_be_i),
    .defer_en_ni (req_defer_en_ni),
    .addr_o      (lat_addr),
    .did_o       (lat_did),
    .be_o        (lat_be),
    .defer_ok_o  (defer_ok)
  );

  dwr_phase_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_type_i   (req_type_i),
    .defer_ok_i   (defer_ok),
    .slot_free_i  (slot_free),
    .data_busy_i  (data_busy_i),
    .data_ready_i (data_ready_i),
    .cap_a_o      (cap_a),
    .cap_b_o      (cap_b),
    .load_o       (load),
    .defer_o      (defer_o),
    .trdy_o       (trdy_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_code_o   (rsp_code_o)
  );

  dwr_fwd_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DID_W(DID_W)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .addr_i      (lat_addr),
    .data_i      (wr_data_i),
    .be_i        (lat_be),
    .did_i       (lat_did),
    .slot_free_o (slot_free),
    .fwd_valid_o (fwd_valid_o),
    .fwd_ready_i (fwd_ready_i),
    .fwd_addr_o  (fwd_addr_o),
    .fwd_data_o  (fwd_data_o),
    .fwd_be_o    (fwd_be_o),
    .fwd_did_o   (fwd_did_o)
  );

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_code_o == 3'b000)); // R7
  AST_NO_TRDY_AT_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_o |-> !trdy_o && !rsp_valid_o); // R6

endmodule

// File: tb/deferred_write_agent_tb.sv
module deferred_write_agent_tb;

  localparam int AW = 32, DW = 64, IW = 8, BW = DW / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_type_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [IW-1:0] req_did_i = '0;
  logic [BW-1:0] req_be_i = '0;
  logic          req_defer_en_ni = 1'b0;
  logic          data_busy_i = 1'b0;
  logic          data_ready_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          fwd_ready_i = 1'b0;
  logic          defer_o, trdy_o, rsp_valid_o, fwd_valid_o;
  logic [2:0]    rsp_code_o;
  logic [AW-1:0] fwd_addr_o;
  logic [DW-1:0] fwd_data_o;
  logic [BW-1:0] fwd_be_o;
  logic [IW-1:0] fwd_did_o;

  always #10 clk_i = ~clk_i;

  deferred_write_agent #(.ADDR_W(AW), .DATA_W(DW), .DID_W(IW)) u_dut (.*);

  int checks = 0;
  int failures = 0;

  bit            slot_full = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [BW-1:0] m_be;
  logic [IW-1:0] m_did;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r = '0;
    for (int b = 0; b < BW; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic quiet(input string req, input string what);
    #1;
    chk(!defer_o, req, {what, " defer"}, defer_o, 0);
    chk(!rsp_valid_o && rsp_code_o == 3'b000, req, {what, " rsp"}, {rsp_valid_o, rsp_code_o}, 0);
    chk(!trdy_o, req, {what, " trdy"}, trdy_o, 0);
  endtask

  task automatic chk_slot(input string req);
    chk(fwd_valid_o == slot_full, req, "fwd_valid", fwd_valid_o, slot_full);
    if (slot_full) begin
      chk(fwd_addr_o == m_addr, req, "fwd_addr", fwd_addr_o, m_addr);
      chk(fwd_data_o == m_data, req, "fwd_data", fwd_data_o, m_data);
      chk(fwd_be_o == m_be, req, "fwd_be", fwd_be_o, m_be);
      chk(fwd_did_o == m_did, req, "fwd_did", fwd_did_o, m_did);
    end
  endtask

  task automatic drain();
    step(); fwd_ready_i = 1'b0; #1;
    chk_slot("R9 hold");
    step(); fwd_ready_i = 1'b1;
    step(); fwd_ready_i = 1'b0; #1;
    slot_full = 0;
    chk(!fwd_valid_o, "R9", "drained", fwd_valid_o, 0);
  endtask

  // snoop_drain: raise fwd_ready_i only in the snoop clock
  task automatic run_txn(input logic [1:0] typ, input bit den_n, input int busy_n,
                         input int dr_delay, input bit snoop_drain, input bit noise);
    logic [AW-1:0] a = $urandom;
    logic [DW-1:0] d = {$urandom, $urandom};
    logic [BW-1:0] be = BW'($urandom);
    logic [IW-1:0] id = IW'($urandom);
    bit exp_def, prev_busy;
    int k;
    // request clock
    step();
    req_valid_i = 1'b1; req_type_i = typ; req_addr_i = a;
    req_did_i = ~id; req_be_i = ~be; req_defer_en_ni = ~den_n;
    quiet("R2", "request clock");
    // second packet
    step();
    req_valid_i = 1'b0; req_addr_i = ~a;
    req_did_i = id; req_be_i = be; req_defer_en_ni = den_n;
    quiet("R3", "packet b clock");
    // snoop clock
    step();
    req_did_i = ~id; req_be_i = ~be; req_defer_en_ni = ~den_n;
    data_busy_i = (busy_n > 0); fwd_ready_i = snoop_drain;
    #1;
    exp_def = den_n && (!slot_full || snoop_drain);
    chk(defer_o == exp_def, "R4", "defer in snoop clock", defer_o, exp_def);
    chk(!trdy_o && !rsp_valid_o, "R6", "snoop clock quiet", {trdy_o, rsp_valid_o}, 0);
    if (snoop_drain) slot_full = 0;
    if (!exp_def) begin
      step(); fwd_ready_i = 1'b0; data_busy_i = 1'b0; #1;
      chk(rsp_valid_o && rsp_code_o == 3'b001, "R5", "retry response",
          {rsp_valid_o, rsp_code_o}, 4'b1001);
      chk(!trdy_o && !defer_o, "R5", "no trdy on retry", {trdy_o, defer_o}, 0);
      step(); #1;
      quiet("R5", "after retry");
      chk_slot("R5 slot untouched");
      return;
    end
    prev_busy = (busy_n > 0);
    k = 1;
    while (prev_busy) begin
      step(); fwd_ready_i = 1'b0; data_busy_i = (k < busy_n); req_valid_i = noise;
      req_type_i = 2'b01; #1;
      chk(!trdy_o, "R6", "trdy while bus busy", trdy_o, 0);
      prev_busy = (k < busy_n);
      k++;
    end
    step(); fwd_ready_i = 1'b0; data_busy_i = 1'b0; req_valid_i = noise; #1;
    chk(trdy_o && !rsp_valid_o, "R6", "trdy clock", {trdy_o, rsp_valid_o}, 2'b10);
    step(); data_ready_i = 1'b1; wr_data_i = ~d; #1;
    chk(rsp_valid_o && rsp_code_o == 3'b010, "R7", "deferred response",
        {rsp_valid_o, rsp_code_o}, 4'b1010);
    chk(!trdy_o, "R6", "trdy single clock", trdy_o, 0);
    for (int i = 0; i < dr_delay; i++) begin
      step(); data_ready_i = 1'b0; wr_data_i = $urandom; #1;
      chk(!rsp_valid_o && rsp_code_o == 3'b000, "R7", "response single clock",
          {rsp_valid_o, rsp_code_o}, 0);
    end
    step(); data_ready_i = 1'b1; wr_data_i = d;
    step(); data_ready_i = 1'b0; req_valid_i = 1'b0; wr_data_i = ~d;
    slot_full = 1; m_addr = a; m_data = lane_mask(d, be); m_be = be; m_did = id;
    #1;
    chk_slot("R8 R9 forwarded write");
    step(); quiet("R2", "post-transaction");
  endtask

  initial begin
    void'($urandom(32'h1d3f_5a07));
    step(); #1;
    chk(!defer_o && !trdy_o && !rsp_valid_o && !fwd_valid_o && rsp_code_o == 0,
        "R1", "outputs in reset", {defer_o, trdy_o, rsp_valid_o, fwd_valid_o, rsp_code_o}, 0);
    step(); step(); rst_ni = 1'b1; #1;
    quiet("R1", "after reset");
    chk(!fwd_valid_o, "R1", "fwd after reset", fwd_valid_o, 0);

    // ignored read types
    for (int t = 0; t < 2; t++) begin
      step(); req_valid_i = 1'b1; req_type_i = (t == 0) ? 2'b00 : 2'b10; req_defer_en_ni = 1'b1;
      step(); req_valid_i = 1'b0;
      for (int c = 0; c < 4; c++) begin step(); quiet("R2", "read type ignored"); end
    end

    // directed
    run_txn(2'b01, 1, 0, 0, 0, 0);   // fastest path
    run_txn(2'b11, 1, 3, 2, 0, 1);   // busy bus, late data, request noise
    run_txn(2'b01, 1, 0, 0, 0, 0);   // slot full -> retry
    run_txn(2'b11, 1, 1, 0, 1, 0);   // drain in snoop clock -> defer
    drain();
    run_txn(2'b01, 0, 0, 0, 0, 0);   // defer forbidden -> retry
    run_txn(2'b01, 1, 0, 1, 0, 1);
    drain();

    // random
    for (int n = 0; n < 60; n++) begin
      bit den = ($urandom % 4) != 0;
      bit sd  = slot_full && ($urandom % 2);
      run_txn(($urandom % 2) ? 2'b11 : 2'b01, den, $urandom % 4, $urandom % 3, sd, $urandom % 2);
      if (slot_full && ($urandom % 3 != 0)) drain();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule